// File: doc/BRIEF.md
# Packed Default Attribute Loader

This block sits behind a register-write port and turns a stream of 32-bit words into four-component attribute vectors. Each component is a 24-bit float that the block treats as an opaque bit pattern. Three consecutive data words carry one vector. Once the third word lands, the vector is unpacked and routed according to a writable slot index.

A slot index below 15 stores the vector in a 15-entry default-attribute table and advances the index. Index 15 selects immediate mode. In that mode the vector is placed in a staging buffer that builds one input vertex, and the index stays put. When the attribute at the configured maximum position arrives, the whole vertex is presented on a valid/ready output.

An index above 15 discards the vector and raises an error pulse. A separate request input arms a reconfiguration marker, which travels with the next emitted vertex.

Top module: `attr_pack_loader`

## Requirements
- R1: Data words are collected three at a time by a counter. Only every third accepted word completes a vector, and the counter then returns to zero. Until a vector completes, neither the index nor the table changes.
- R2: For words taken in the order a, b, c, the components are: w = a[31:8], z = {a[7:0], b[31:16]}, y = {b[15:0], c[31:24]}, x = c[23:0]. A vector is laid out as {w, z, y, x}, with x in bits [23:0] and w in bits [95:72].
- R3: When a vector completes with index below 15, it is written to table slot [index], and the index becomes index+1 on the same clock edge. Slot k is read on `tbl_rdata` when `tbl_raddr` is k; an address of 15 reads zero.
- R4: When a vector completes with index 15, it is written to the staging buffer at the current immediate position, and the index keeps the value 15.
- R5: When a vector completes with index 16 to 31, it is dropped. `err` is high for exactly one cycle after that edge. The index and the table are unchanged.
- R6: After each staged write, the immediate position advances while it is below `max_attr`. The write at `max_attr` resets the position to zero and raises `vtx_valid`. Attribute k of the vertex is `vtx_data[k*96 +: 96]`.
- R7: While `vtx_valid` is high and `vtx_ready` is low, `vtx_data` holds steady and `busy` is high. Data and index writes made while busy are ignored. `vtx_valid` drops on the edge where `vtx_ready` is high.
- R8: A pulse on `reconf_req` arms a pending marker. The next emitted vertex carries `vtx_reconf` = 1, which clears the marker, so later vertices carry 0.
- R9: A synchronous reset clears the word counter, the immediate position, `vtx_valid`, the pending marker and the index (to 0). Table contents survive reset.
- R10: An index write resets the word counter, so the next data word starts a new vector. An index write takes priority over a data write in the same cycle, and that data word is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Data word strobe |
| wr_data | input | 32 | Packed data word |
| idx_wr_en | input | 1 | Slot index write strobe |
| idx_wr_data | input | 5 | New slot index |
| max_attr | input | 4 | Highest immediate attribute position |
| reconf_req | input | 1 | Arms the reconfiguration marker |
| tbl_raddr | input | 4 | Table read address |
| tbl_rdata | output | 96 | Table entry at `tbl_raddr` |
| cur_idx | output | 5 | Current slot index |
| err | output | 1 | Pulse on a dropped vector |
| busy | output | 1 | Writes are not accepted |
| vtx_valid | output | 1 | Assembled vertex available |
| vtx_ready | input | 1 | Consumer takes the vertex |
| vtx_data | output | 1536 | Staged vertex, 16 attributes of 96 bits |
| vtx_reconf | output | 1 | Reconfiguration marker for this vertex |

## Verification
The following properties are checked on every cycle:
- A stalled vertex keeps its data.
- No vector completes while busy.
- A table write advances the index by one.
- An immediate write leaves the index alone.
- Every error pulse follows an index above 15.
- A fresh emission leaves the position at zero.

The bench scenarios are needed for the rest. They show the exact bit placement of the unpacked components and the table contents after full sweeps of the index range. They also show where each emission falls for every maximum position from 0 to 3. Finally, they show that the reconfiguration marker appears once, that a dropped or reset partial vector does not shift later packing, and that the table survives reset.

// File: rtl/attr_pkg.sv
package attr_pkg;
  localparam int COMP_W = 24;
  localparam int WORD_W = 32;
  localparam int VEC_W  = 4 * COMP_W;

  // Split three words into {w,z,y,x}; first word supplies w.
  function automatic logic [VEC_W-1:0] unpack3(input logic [WORD_W-1:0] a,
                                               input logic [WORD_W-1:0] b,
                                               input logic [WORD_W-1:0] c);
    logic [COMP_W-1:0] cw, cz, cy, cx;
    cw = a[31:8];
    cz = {a[7:0], b[31:16]};
    cy = {b[15:0], c[31:24]};
    cx = c[23:0];
    return {cw, cz, cy, cx};
  endfunction
endpackage

// File: rtl/word_collector.sv
module word_collector
  import attr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic              restart,
  input  logic [WORD_W-1:0] data,
  output logic              done,
  output logic [VEC_W-1:0]  vec
);
  logic [1:0]        cnt;
  logic [WORD_W-1:0] hold0, hold1;

  assign done = push && (cnt == 2'd2);
  assign vec  = unpack3(hold0, hold1, data);

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      cnt <= 2'd0;
    end else if (push) begin
      cnt <= (cnt == 2'd2) ? 2'd0 : cnt + 2'd1;
      if (cnt == 2'd0) hold0 <= data;
      if (cnt == 2'd1) hold1 <= data;
    end
  end
endmodule

// File: rtl/default_table.sv
module default_table
  import attr_pkg::*;
#(
  parameter int ENTRIES = 15,
  parameter int AW      = 4
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [VEC_W-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [VEC_W-1:0] rdata
);
  logic [VEC_W-1:0] slot [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (we && (waddr == AW'(g))) slot[g] <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    for (int k = 0; k < ENTRIES; k++)
      if (raddr == AW'(k)) rdata = slot[k];
  end
endmodule

// File: rtl/imm_assembler.sv
module imm_assembler
  import attr_pkg::*;
#(
  parameter int ATTRS = 16,
  parameter int PW    = $clog2(ATTRS)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   we,
  input  logic [VEC_W-1:0]       wdata,
  input  logic [PW-1:0]          max_attr,
  input  logic                   reconf_req,
  input  logic                   ready,
  output logic                   valid,
  output logic [ATTRS*VEC_W-1:0] vertex,
  output logic                   reconf_o,
  output logic [PW-1:0]          pos,
  output logic                   emit
);
  logic [VEC_W-1:0] stage [ATTRS];
  logic             pending;

  assign emit = we && (pos >= max_attr);

  for (genvar g = 0; g < ATTRS; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (we && (pos == PW'(g))) stage[g] <= wdata;
    end
    assign vertex[g*VEC_W +: VEC_W] = stage[g];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pos      <= '0;
      valid    <= 1'b0;
      pending  <= 1'b0;
      reconf_o <= 1'b0;
    end else begin
      if (we) pos <= emit ? '0 : pos + PW'(1);
      if (emit) begin
        valid    <= 1'b1;
        reconf_o <= pending;
      end else if (ready) begin
        valid <= 1'b0;
      end
      pending <= reconf_req || (pending && !emit);
    end
  end
endmodule

// File: rtl/attr_pack_loader.sv
module attr_pack_loader
  import attr_pkg::*;
#(
  parameter int IDX_W     = 5,
  parameter int NUM_SLOTS = 15,
  parameter int IMM_ATTRS = 16
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic [WORD_W-1:0]          wr_data,
  input  logic                       idx_wr_en,
  input  logic [IDX_W-1:0]           idx_wr_data,
  input  logic [$clog2(IMM_ATTRS)-1:0] max_attr,
  input  logic                       reconf_req,
  input  logic [$clog2(NUM_SLOTS+1)-1:0] tbl_raddr,
  output logic [VEC_W-1:0]           tbl_rdata,
  output logic [IDX_W-1:0]           cur_idx,
  output logic                       err,
  output logic                       busy,
  output logic                       vtx_valid,
  input  logic                       vtx_ready,
  output logic [IMM_ATTRS*VEC_W-1:0] vtx_data,
  output logic                       vtx_reconf
);
  localparam int PW = $clog2(IMM_ATTRS);
  localparam int AW = $clog2(NUM_SLOTS+1);
  localparam logic [IDX_W-1:0] IMM_IDX = IDX_W'(NUM_SLOTS);

  // Named internal events (observed by the checker)
  logic             idx_load, data_push, vec_done;
  logic             tbl_we, imm_we, drop_vec, emit;
  logic [VEC_W-1:0] vec;
  logic [PW-1:0]    imm_pos;

  assign busy      = vtx_valid;
  assign idx_load  = idx_wr_en && !busy;
  assign data_push = wr_en && !busy && !idx_wr_en;
  assign tbl_we    = vec_done && (cur_idx <  IMM_IDX);
  assign imm_we    = vec_done && (cur_idx == IMM_IDX);
  assign drop_vec  = vec_done && (cur_idx >  IMM_IDX);

  word_collector u_coll (
    .clk(clk), .rst(rst), .push(data_push), .restart(idx_load),
    .data(wr_data), .done(vec_done), .vec(vec)
  );

  default_table #(.ENTRIES(NUM_SLOTS), .AW(AW)) u_tbl (
    .clk(clk), .we(tbl_we), .waddr(AW'(cur_idx)), .wdata(vec),
    .raddr(tbl_raddr), .rdata(tbl_rdata)
  );

  imm_assembler #(.ATTRS(IMM_ATTRS), .PW(PW)) u_imm (
    .clk(clk), .rst(rst), .we(imm_we), .wdata(vec), .max_attr(max_attr),
    .reconf_req(reconf_req), .ready(vtx_ready), .valid(vtx_valid),
    .vertex(vtx_data), .reconf_o(vtx_reconf), .pos(imm_pos), .emit(emit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_idx <= '0;
      err     <= 1'b0;
    end else begin
      err <= drop_vec;
      if (idx_load)    cur_idx <= idx_wr_data;
      else if (tbl_we) cur_idx <= cur_idx + IDX_W'(1);
    end
  end
endmodule

// File: rtl/attr_loader_chk.sv
module attr_loader_chk #(
  parameter int IDX_W = 5,
  parameter int NUM_SLOTS = 15,
  parameter int PW = 4,
  parameter int DW = 1536
) (
  input logic             clk,
  input logic             rst,
  input logic             vtx_valid,
  input logic             vtx_ready,
  input logic [DW-1:0]    vtx_data,
  input logic             busy,
  input logic             vec_done,
  input logic             tbl_we,
  input logic             imm_we,
  input logic             err,
  input logic [IDX_W-1:0] cur_idx,
  input logic [PW-1:0]    imm_pos
);
  // R7
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    vtx_valid && !vtx_ready |=> vtx_valid && $stable(vtx_data));
  // R7
  busy_block_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> !vec_done);
  // R3
  idx_step_chk: assert property (@(posedge clk) disable iff (rst)
    tbl_we |=> cur_idx == IDX_W'($past(cur_idx) + IDX_W'(1)));
  // R4
  imm_idx_hold_chk: assert property (@(posedge clk) disable iff (rst)
    imm_we |=> $stable(cur_idx));
  // R5
  err_src_chk: assert property (@(posedge clk) disable iff (rst)
    err |-> $past(cur_idx) > IDX_W'(NUM_SLOTS));
  // R6
  emit_pos_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(vtx_valid) |-> imm_pos == '0);
endmodule

bind attr_pack_loader attr_loader_chk #(
  .IDX_W(IDX_W), .NUM_SLOTS(NUM_SLOTS), .PW(PW), .DW(IMM_ATTRS*attr_pkg::VEC_W)
) u_chk (
  .clk(clk), .rst(rst), .vtx_valid(vtx_valid), .vtx_ready(vtx_ready),
  .vtx_data(vtx_data), .busy(busy), .vec_done(vec_done), .tbl_we(tbl_we),
  .imm_we(imm_we), .err(err), .cur_idx(cur_idx), .imm_pos(imm_pos)
);

// File: tb/sim_attr_pack_loader.sv
`timescale 1ns/1ps
module sim_attr_pack_loader;
  logic clk = 0, rst = 1;
  logic wr_en = 0, idx_wr_en = 0, reconf_req = 0, vtx_ready = 0;
  logic [31:0] wr_data = '0;
  logic [4:0] idx_wr_data = '0;
  logic [3:0] max_attr = '0, tbl_raddr = '0;
  logic [95:0] tbl_rdata;
  logic [4:0] cur_idx;
  logic err, busy, vtx_valid, vtx_reconf;
  logic [1535:0] vtx_data;
  int checks = 0, failures = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  attr_pack_loader u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .idx_wr_en(idx_wr_en), .idx_wr_data(idx_wr_data), .max_attr(max_attr),
    .reconf_req(reconf_req), .tbl_raddr(tbl_raddr), .tbl_rdata(tbl_rdata),
    .cur_idx(cur_idx), .err(err), .busy(busy), .vtx_valid(vtx_valid),
    .vtx_ready(vtx_ready), .vtx_data(vtx_data), .vtx_reconf(vtx_reconf)
  );

  task automatic chk(input bit ok, input string req, input logic [127:0] act,
                     input logic [127:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Bench-side pattern: components built arithmetically per seed
  function automatic logic [95:0] mkvec(input int s);
    logic [23:0] cw, cz, cy, cx;
    cx = 24'(s * 24'h010203 + 24'h000011);
    cy = 24'(s * 24'h0A0B0C + 24'h220000);
    cz = 24'(s * 24'h131313 + 24'h003300);
    cw = 24'(~(s * 24'h070605));
    return {cw, cz, cy, cx};
  endfunction

  // Expected packing: the three words are the vector split big-end first
  function automatic logic [31:0] word_of(input logic [95:0] v, input int k);
    return 32'(v >> (64 - 32*k));
  endfunction

  task automatic put_word(input logic [31:0] d);
    @(negedge clk); wr_en = 1; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic put_vec(input logic [95:0] v);
    for (int k = 0; k < 3; k++) put_word(word_of(v, k));
  endtask

  task automatic set_idx(input logic [4:0] v);
    @(negedge clk); idx_wr_en = 1; idx_wr_data = v;
    @(negedge clk); idx_wr_en = 0;
  endtask

  task automatic read_slot(input int s, output logic [95:0] d);
    tbl_raddr = 4'(s); #1; d = tbl_rdata;
  endtask

  task automatic release_vtx();
    @(negedge clk); vtx_ready = 1;
    @(negedge clk); vtx_ready = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [95:0] rd;
    logic [1535:0] snap;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R9 reset state
    chk(!vtx_valid && !busy && !err && cur_idx == 0, "R9 reset outputs",
        {vtx_valid, busy, err, cur_idx}, 0);

    // R1: two words alone complete nothing
    put_word(word_of(mkvec(0), 0));
    put_word(word_of(mkvec(0), 1));
    chk(cur_idx == 0, "R1 no completion after two words", cur_idx, 0);
    put_word(word_of(mkvec(0), 2));
    chk(cur_idx == 1, "R1 completion on third word", cur_idx, 1);

    // R2/R3: fill every table slot
    set_idx(0);
    for (int s = 0; s < 15; s++) begin
      put_vec(mkvec(s));
      chk(cur_idx == 5'(s + 1), "R3 index advance", cur_idx, s + 1);
    end
    for (int s = 0; s < 15; s++) begin
      read_slot(s, rd);
      chk(rd == mkvec(s), "R2 R3 table slot content", rd, mkvec(s));
    end
    read_slot(15, rd);
    chk(rd == 0, "R3 address 15 reads zero", rd, 0);

    // R10: partial vector abandoned by index write
    put_word(32'h11111111);
    put_word(32'h22222222);
    set_idx(4);
    put_vec(mkvec(40));
    read_slot(4, rd);
    chk(rd == mkvec(40), "R10 packing restarts after index write", rd, mkvec(40));
    chk(cur_idx == 5, "R10 index after restart", cur_idx, 5);
    // R10: simultaneous index and data write drops the data word
    @(negedge clk); idx_wr_en = 1; idx_wr_data = 6; wr_en = 1; wr_data = 32'hFFFFFFFF;
    @(negedge clk); idx_wr_en = 0; wr_en = 0;
    put_vec(mkvec(41));
    read_slot(6, rd);
    chk(rd == mkvec(41), "R10 index write has priority", rd, mkvec(41));
    set_idx(4); put_vec(mkvec(4)); put_vec(mkvec(5)); put_vec(mkvec(6));

    // R5: every out-of-range index
    for (int i = 16; i < 32; i++) begin
      set_idx(5'(i));
      put_vec(mkvec(200 + i));
      chk(err == 1, "R5 error pulse", err, 1);
      chk(cur_idx == 5'(i), "R5 index unchanged", cur_idx, i);
      @(negedge clk);
      chk(err == 0, "R5 error single cycle", err, 0);
    end
    for (int s = 0; s < 15; s++) begin
      read_slot(s, rd);
      chk(rd == mkvec(s), "R5 table untouched", rd, mkvec(s));
    end

    // R4/R6/R7: immediate vertices for max 0..3
    for (int m = 0; m < 4; m++) begin
      max_attr = 4'(m);
      set_idx(15);
      for (int a = 0; a <= m; a++) begin
        put_vec(mkvec(100 + m*8 + a));
        if (a < m) chk(!vtx_valid, "R6 no emission before max", vtx_valid, 0);
      end
      chk(vtx_valid && busy, "R6 R7 emission at max", {vtx_valid, busy}, 3);
      chk(cur_idx == 15, "R4 index stays 15", cur_idx, 15);
      chk(vtx_reconf == 0, "R8 no marker without request", vtx_reconf, 0);
      for (int a = 0; a <= m; a++)
        chk(vtx_data[a*96 +: 96] == mkvec(100 + m*8 + a), "R6 vertex attribute",
            vtx_data[a*96 +: 96], mkvec(100 + m*8 + a));
      snap = vtx_data;
      put_word(32'hDEADBEEF);
      set_idx(3);
      repeat (2) @(negedge clk);
      chk(vtx_valid && vtx_data == snap, "R7 held under stall", vtx_valid, 1);
      chk(cur_idx == 15, "R7 index write ignored while busy", cur_idx, 15);
      release_vtx();
      chk(!vtx_valid && !busy, "R7 valid drops after ready", vtx_valid, 0);
    end
    // R7: the word dropped while busy did not shift packing
    max_attr = 0;
    put_vec(mkvec(77));
    chk(vtx_valid && vtx_data[95:0] == mkvec(77), "R7 dropped word left no trace",
        vtx_data[95:0], mkvec(77));
    release_vtx();

    // R8: marker on the first vertex only
    @(negedge clk); reconf_req = 1;
    @(negedge clk); reconf_req = 0;
    put_vec(mkvec(78));
    chk(vtx_valid && vtx_reconf, "R8 marker on first vertex", vtx_reconf, 1);
    release_vtx();
    put_vec(mkvec(79));
    chk(vtx_valid && !vtx_reconf, "R8 marker cleared", vtx_reconf, 0);
    release_vtx();

    // R9: reset mid-vertex and mid-vector
    max_attr = 1;
    put_vec(mkvec(80));
    put_word(32'hCAFEF00D);
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    chk(cur_idx == 0 && !vtx_valid, "R9 state after reset", cur_idx, 0);
    read_slot(7, rd);
    chk(rd == mkvec(7), "R9 table survives reset", rd, mkvec(7));
    set_idx(15);
    put_vec(mkvec(81));
    chk(!vtx_valid, "R9 position cleared by reset", vtx_valid, 0);
    put_vec(mkvec(82));
    chk(vtx_valid && vtx_data[95:0] == mkvec(81) && vtx_data[191:96] == mkvec(82),
        "R9 fresh vertex after reset", vtx_data[191:0], {mkvec(82), mkvec(81)});
    release_vtx();

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule